// File: doc/BRIEF.md
# Planar Graphics Write Datapath

This block sits between a CPU byte port and four 8-bit bit-planes that share one address space. A CPU read fetches the addressed byte from all four planes at once. It keeps the four bytes in a 32-bit latch and returns the byte of one selected plane. A CPU write does not store the host byte directly. For each plane, the block builds a byte from the rotated host byte, a per-plane colour bit or the host's low bits, depending on the write mode. It combines that byte with the latched plane byte through a logic operation, then merges the result with the latch under a bit mask. Only the planes whose write enable is set are stored.

The configuration arrives as static input ports: write mode, rotate count, logic operation, colour, colour enable, bit mask, plane write enable and read-plane select. A typical use is a read followed by a write to the same address. The read fills the latch, and the write then alters the selected pixels of every plane while leaving the rest as they were.

Top module: `plane_write_path`

## Requirements
- R1: A read (`cpu_req`=1, `cpu_we`=0) raises `cpu_rvalid` for one cycle, two rising edges after the request edge. `cpu_rdata` then holds the addressed byte of plane `cfg_rd_plane` as it was sampled at the request. `cpu_rdata` does not change while `cpu_rvalid` is low.
- R2: In write mode 0 (`cfg_wmode`=0), with colour enable 0, logic code 0 and mask 8'hFF, every enabled plane receives the host byte rotated right by `cfg_rot` places.
- R3: The logic code `cfg_lop` combines the source byte with the latched plane byte: 0 passes the source, 1 is AND, 2 is OR and 3 is XOR.
- R4: In mode 0, a plane p with `cfg_esr[p]`=1 uses `cfg_sr[p]` copied to all 8 bits in place of the rotated host byte.
- R5: Bit positions where `cfg_bitmask` is 0 take the latched bit, and positions where it is 1 take the computed bit. This holds in modes 0, 2 and 3.
- R6: Only planes p with `cfg_plane_we[p]`=1 are written. The other planes keep their content.
- R7: In write mode 1, each enabled plane receives its latched byte. The host data, logic code and mask have no effect.
- R8: In write mode 2, plane p uses host bit p copied to all 8 bits as its source. The rotate count is ignored.
- R9: In write mode 3, plane p uses `cfg_sr[p]` copied to all 8 bits as its source, and the effective mask is the rotated host byte ANDed with `cfg_bitmask`.
- R10: A write issued on the cycle right after a read uses the latch contents that this read loaded. When the mask and mode make the result depend only on the latch, the stored bytes are independent of the host byte.
- R11: After reset, `cpu_rvalid` and `cpu_rdata` are 0 and the latch holds zero. A mode 1 write before any read therefore stores zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address common to all planes |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Read byte from the selected plane |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cfg_wmode | input | 2 | Write mode 0..3 |
| cfg_rot | input | 3 | Right-rotate count for the host byte |
| cfg_lop | input | 2 | Logic operation code |
| cfg_sr | input | 4 | Per-plane colour bits |
| cfg_esr | input | 4 | Per-plane colour substitution enable (mode 0) |
| cfg_bitmask | input | 8 | Per-bit write mask |
| cfg_plane_we | input | 4 | Per-plane write enable |
| cfg_rd_plane | input | 2 | Plane returned by a read |

## Verification
The assertions assume that `cpu_req` carries at most one access per cycle. They also assume that the configuration ports are steady on the cycle a write is presented and that no access is presented while `rst` is high. The bench changes configuration only between accesses and keeps `cpu_req` low during reset. Each table vector preloads its own address plane by plane, reads it, and issues the configured write on the very next cycle, so every write sees a latch value that the preceding read has just loaded.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int BYTE_W = 8;
  localparam int ROT_W  = $clog2(BYTE_W);
  localparam int NPLANE = 4;
  localparam int SEL_W  = $clog2(NPLANE);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    WM_HOST   = 2'd0,
    WM_LATCH  = 2'd1,
    WM_COLOR  = 2'd2,
    WM_MASKED = 2'd3
  } wmode_e;

  typedef enum logic [1:0] {
    LOP_PASS = 2'd0,
    LOP_AND  = 2'd1,
    LOP_OR   = 2'd2,
    LOP_XOR  = 2'd3
  } lop_e;
endpackage

// File: rtl/pwd_rotator.sv
module pwd_rotator
  import pwd_pkg::*;
(
  input  byte_t            din,
  input  logic [ROT_W-1:0] cnt,
  output byte_t            dout
);
  // right rotate: output bit i takes input bit (i + cnt) mod width
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign dout[i] = din[ROT_W'(i) + cnt];
  end
endmodule

// File: rtl/pwd_plane_lane.sv
module pwd_plane_lane
  import pwd_pkg::*;
(
  input  wmode_e wmode,
  input  lop_e   lop,
  input  logic   color_bit,
  input  logic   color_en,
  input  logic   host_bit,
  input  byte_t  host_rot,
  input  byte_t  bitmask,
  input  byte_t  latch,
  output byte_t  wbyte
);
  byte_t src;
  byte_t msk;
  byte_t alu;

  always_comb begin
    src = host_rot;
    msk = bitmask;
    unique case (wmode)
      WM_HOST:   src = color_en ? {BYTE_W{color_bit}} : host_rot;
      WM_LATCH:  src = latch;
      WM_COLOR:  src = {BYTE_W{host_bit}};
      WM_MASKED: begin
        src = {BYTE_W{color_bit}};
        msk = host_rot & bitmask;
      end
      default:   src = host_rot;
    endcase
  end

  always_comb begin
    unique case (lop)
      LOP_PASS: alu = src;
      LOP_AND:  alu = src & latch;
      LOP_OR:   alu = src | latch;
      LOP_XOR:  alu = src ^ latch;
      default:  alu = src;
    endcase
  end

  always_comb begin
    if (wmode == WM_LATCH) wbyte = latch;
    else                   wbyte = (alu & msk) | (latch & ~msk);
  end
endmodule

// File: rtl/pwd_plane_ram.sv
module pwd_plane_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/plane_write_path.sv
module plane_write_path
  import pwd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [BYTE_W-1:0]    cpu_wdata,
  output logic [BYTE_W-1:0]    cpu_rdata,
  output logic                 cpu_rvalid,
  input  logic [1:0]           cfg_wmode,
  input  logic [ROT_W-1:0]     cfg_rot,
  input  logic [1:0]           cfg_lop,
  input  logic [NPLANE-1:0]    cfg_sr,
  input  logic [NPLANE-1:0]    cfg_esr,
  input  logic [BYTE_W-1:0]    cfg_bitmask,
  input  logic [NPLANE-1:0]    cfg_plane_we,
  input  logic [SEL_W-1:0]     cfg_rd_plane
);
  logic rd_req;
  logic wr_req;
  logic rd_pend;
  logic [SEL_W-1:0] sel_q;

  logic [NPLANE-1:0][BYTE_W-1:0] ram_q;
  logic [NPLANE-1:0][BYTE_W-1:0] latch_q;
  logic [NPLANE-1:0][BYTE_W-1:0] lat_eff;
  logic [NPLANE-1:0][BYTE_W-1:0] wr_bytes;
  logic [NPLANE-1:0]             ram_we;
  byte_t host_rot;

  assign rd_req = cpu_req & ~cpu_we;
  assign wr_req = cpu_req & cpu_we;

  // a write right behind a read sees the bytes that read is loading
  assign lat_eff = rd_pend ? ram_q : latch_q;

  pwd_rotator u_rot (
    .din  (cpu_wdata),
    .cnt  (cfg_rot),
    .dout (host_rot)
  );

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    pwd_plane_lane u_lane (
      .wmode     (wmode_e'(cfg_wmode)),
      .lop       (lop_e'(cfg_lop)),
      .color_bit (cfg_sr[p]),
      .color_en  (cfg_esr[p]),
      .host_bit  (cpu_wdata[p]),
      .host_rot  (host_rot),
      .bitmask   (cfg_bitmask),
      .latch     (lat_eff[p]),
      .wbyte     (wr_bytes[p])
    );

    assign ram_we[p] = wr_req & cfg_plane_we[p];

    pwd_plane_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
      .clk   (clk),
      .we    (ram_we[p]),
      .re    (rd_req),
      .addr  (cpu_addr),
      .wdata (wr_bytes[p]),
      .q     (ram_q[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend    <= 1'b0;
      sel_q      <= '0;
      latch_q    <= '0;
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      rd_pend    <= rd_req;
      cpu_rvalid <= rd_pend;
      if (rd_req) sel_q <= cfg_rd_plane;
      if (rd_pend) begin
        latch_q   <= ram_q;
        cpu_rdata <= ram_q[sel_q];
      end
    end
  end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
  parameter int NPLANE = 4,
  parameter int BYTE_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cpu_req,
  input logic                     cpu_we,
  input logic [BYTE_W-1:0]        cpu_wdata,
  input logic [BYTE_W-1:0]        cpu_rdata,
  input logic                     cpu_rvalid,
  input logic [1:0]               cfg_wmode,
  input logic [1:0]               cfg_lop,
  input logic [BYTE_W-1:0]        cfg_bitmask,
  input logic                     rd_pend,
  input logic [NPLANE*BYTE_W-1:0] latch_q,
  input logic [NPLANE*BYTE_W-1:0] lat_eff,
  input logic [NPLANE*BYTE_W-1:0] wr_bytes
);
  logic [NPLANE*BYTE_W-1:0] host_expand;

  always_comb begin
    for (int p = 0; p < NPLANE; p++)
      host_expand[p*BYTE_W +: BYTE_W] = {BYTE_W{cpu_wdata[p]}};
  end

  // R1: a read returns valid data two edges later
  a_r1_read_valid: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_we) |=> ##1 cpu_rvalid);

  // R1: returned byte is held between reads
  a_r1_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !cpu_rvalid |-> $stable(cpu_rdata));

  // R10: the latch only moves after a read
  a_r10_latch_on_read: assert property (@(posedge clk) disable iff (rst)
    !$stable(latch_q) |-> $past(rd_pend));

  // R7: mode 1 stores the latch unchanged
  a_r7_mode1_copies_latch: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cfg_wmode == 2'd1) |-> wr_bytes == lat_eff);

  // R5: an all-clear mask leaves every plane at its latched byte
  a_r5_zero_mask_keeps_latch: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cfg_bitmask == '0) |-> wr_bytes == lat_eff);

  // R8: mode 2, pass, full mask stores the expanded host bits
  a_r8_mode2_expand: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_we && cfg_wmode == 2'd2 && cfg_lop == 2'd0 && cfg_bitmask == '1)
      |-> wr_bytes == host_expand);
endmodule

bind plane_write_path pwd_checker #(.NPLANE(pwd_pkg::NPLANE), .BYTE_W(pwd_pkg::BYTE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_req     (cpu_req),
  .cpu_we      (cpu_we),
  .cpu_wdata   (cpu_wdata),
  .cpu_rdata   (cpu_rdata),
  .cpu_rvalid  (cpu_rvalid),
  .cfg_wmode   (cfg_wmode),
  .cfg_lop     (cfg_lop),
  .cfg_bitmask (cfg_bitmask),
  .rd_pend     (rd_pend),
  .latch_q     (latch_q),
  .lat_eff     (lat_eff),
  .wr_bytes    (wr_bytes)
);

// File: tb/plane_write_path_bench.sv
module plane_write_path_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int NVEC = 12;

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  wm;
    logic [2:0]  rot;
    logic [1:0]  lop;
    logic [3:0]  sr;
    logic [3:0]  esr;
    logic [7:0]  bm;
    logic [3:0]  pwe;
    logic [7:0]  host;
    logic [31:0] exp;   // plane 3 .. plane 0
  } vec_t;

  // preload for every vector: plane3=F0 plane2=3C plane1=AA plane0=55
  localparam logic [31:0] PRE = 32'hF0_3C_AA_55;

  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  2'd0, 3'd3, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h81, 32'h30_30_30_30}, // R2 rotate by 3
    '{4'd3,  2'd0, 3'd0, 2'd1, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h0F, 32'h00_0C_0A_05}, // R3 AND
    '{4'd3,  2'd0, 3'd0, 2'd2, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h0F, 32'hFF_3F_AF_5F}, // R3 OR
    '{4'd3,  2'd0, 3'd0, 2'd3, 4'h0, 4'h0, 8'hFF, 4'hF, 8'hFF, 32'h0F_C3_55_AA}, // R3 XOR
    '{4'd4,  2'd0, 3'd0, 2'd0, 4'h1, 4'h5, 8'hFF, 4'hF, 8'h66, 32'h66_00_66_FF}, // R4 colour per plane
    '{4'd5,  2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hF0, 4'hF, 8'hFF, 32'hF0_FC_FA_F5}, // R5 bit mask
    '{4'd6,  2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'h5, 8'h00, 32'hF0_00_AA_00}, // R6 plane enable
    '{4'd7,  2'd1, 3'd2, 2'd3, 4'h0, 4'h0, 8'h00, 4'hF, 8'h12, 32'hF0_3C_AA_55}, // R7 latch copy
    '{4'd8,  2'd2, 3'd5, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF, 8'h0A, 32'hFF_00_FF_00}, // R8 host bit expand
    '{4'd9,  2'd3, 3'd4, 2'd0, 4'h6, 4'h0, 8'hF0, 4'hF, 8'h3C, 32'h30_FC_EA_15}, // R9 masked colour
    '{4'd8,  2'd2, 3'd0, 2'd2, 4'h0, 4'h0, 8'h0F, 4'hF, 8'h05, 32'hF0_3F_AA_5F}, // R8 with OR and mask
    '{4'd4,  2'd0, 3'd0, 2'd3, 4'hA, 4'hF, 8'hFF, 4'hF, 8'h77, 32'h0F_3C_55_55}  // R4 colour with XOR
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic [7:0]        cpu_rdata;
  logic              cpu_rvalid;
  logic [1:0]        cfg_wmode = '0;
  logic [2:0]        cfg_rot = '0;
  logic [1:0]        cfg_lop = '0;
  logic [3:0]        cfg_sr = '0;
  logic [3:0]        cfg_esr = '0;
  logic [7:0]        cfg_bitmask = 8'hFF;
  logic [3:0]        cfg_plane_we = 4'hF;
  logic [1:0]        cfg_rd_plane = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plane_write_path #(.ADDR_W(ADDR_W)) u_plane_write_path (
    .clk, .rst, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_rvalid,
    .cfg_wmode, .cfg_rot, .cfg_lop, .cfg_sr, .cfg_esr, .cfg_bitmask,
    .cfg_plane_we, .cfg_rd_plane
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic set_cfg(input logic [1:0] wm, input logic [2:0] rot, input logic [1:0] lop,
                         input logic [3:0] sr, input logic [3:0] esr,
                         input logic [7:0] bm, input logic [3:0] pwe);
    cfg_wmode = wm; cfg_rot = rot; cfg_lop = lop; cfg_sr = sr;
    cfg_esr = esr; cfg_bitmask = bm; cfg_plane_we = pwe;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] pl, output logic [7:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cfg_rd_plane = pl;
    @(negedge clk);
    cpu_req = 1'b0;
    @(negedge clk);
    d = cpu_rdata;
  endtask

  task automatic preload(input logic [ADDR_W-1:0] a);
    for (int p = 0; p < 4; p++) begin
      set_cfg(2'd0, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'(1 << p));
      wr(a, PRE[p*8 +: 8]);
    end
  endtask

  // read, then the write on the very next cycle (latch forwarding)
  task automatic rd_then_wr(input logic [ADDR_W-1:0] a, input logic [7:0] host,
                            output logic [7:0] d0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cfg_rd_plane = 2'd0;
    @(negedge clk);
    cpu_we = 1'b1; cpu_wdata = host;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    d0 = cpu_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] e;
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset rvalid", {31'd0, cpu_rvalid}, 32'd0);
    check("R11 reset rdata", {24'd0, cpu_rdata}, 32'd0);

    // R11: latch is zero after reset, mode 1 write stores zeros
    set_cfg(2'd1, 3'd0, 2'd0, 4'h0, 4'h0, 8'hFF, 4'hF);
    wr(8'd200, 8'hA5);
    got = '0;
    for (int p = 0; p < 4; p++) begin
      rd(8'd200, 2'(p), d);
      got[p*8 +: 8] = d;
    end
    check("R11 mode1 write of reset latch", got, 32'd0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'(v + 1);
      preload(a);
      set_cfg(VECS[v].wm, VECS[v].rot, VECS[v].lop, VECS[v].sr, VECS[v].esr,
              VECS[v].bm, VECS[v].pwe);
      rd_then_wr(a, VECS[v].host, d);
      check($sformatf("R1 vector %0d read of plane 0", v), {24'd0, d}, {24'd0, PRE[7:0]});
      for (int p = 0; p < 4; p++) begin
        rd(a, 2'(p), d);
        check($sformatf("R%0d vector %0d plane %0d", VECS[v].tag, v, p),
              {24'd0, d}, {24'd0, VECS[v].exp[p*8 +: 8]});
      end
    end

    // R1: rvalid timing and plane select
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd1; cfg_rd_plane = 2'd3;
    @(negedge clk);
    cpu_req = 1'b0;
    check("R1 rvalid low one edge after read", {31'd0, cpu_rvalid}, 32'd0);
    @(negedge clk);
    check("R1 rvalid high two edges after read", {31'd0, cpu_rvalid}, 32'd1);
    check("R1 rdata plane 3", {24'd0, cpu_rdata}, 32'h30);
    @(negedge clk);
    check("R1 rvalid single pulse", {31'd0, cpu_rvalid}, 32'd0);

    // R10: result independent of host data when only latch matters
    preload(8'd100);
    preload(8'd101);
    set_cfg(2'd0, 3'd1, 2'd3, 4'h0, 4'hF, 8'hFF, 4'hF);
    rd_then_wr(8'd100, 8'h00, d);
    rd_then_wr(8'd101, 8'hFF, d);
    rd(8'd100, 2'd1, d);
    rd(8'd101, 2'd1, e);
    check("R10 host 00 keeps latch", {24'd0, d}, 32'hAA);
    check("R10 host FF keeps latch", {24'd0, e}, 32'hAA);

    summary();
  end
endmodule